// File: doc/BRIEF.md
# Operand-Holding Issue Stage

This stage sits between an instruction decoder and the execution units. The decoder hands it at most one instruction per cycle. Each instruction carries a tag and, for each source operand, a register number, a bank select (integer or floating-point half of a shared register file) and a pending flag. On the cycle an instruction is taken in, the stage forms the register-file read addresses and reads each operand once. It then holds the instruction in an internal register and issues it when every operand is current and the downstream units raise `can_issue`.

The stall signal back to the decoder comes straight from a flop. It goes high only because the stage held an instruction that did not issue in the previous cycle. Because of this one-cycle delay, the decoder can hand over one more instruction while the held one is still waiting. A one-entry skid slot keeps that instruction. While the stage waits, it watches the register-file write port. Any writeback whose address matches a held operand replaces that operand's value and marks it current, so the file is never read a second time. A flush empties both slots.

Top module: `iss_stage`

## Requirements
- R1: While reset is active, and in the first cycle after it, `stall_out` and `iss_valid` are low.
- R2: `rf_addr[i]` is combinationally `{in_fp[i], in_reg[i]}`. Bit REG_W selects the floating-point bank and the low REG_W bits are the register number.
- R3: An instruction is taken in at a clock edge where `in_valid` is high and `stall_out` and `flush` are low. It can issue no earlier than the next cycle. `iss_valid` is high in a cycle exactly when the held instruction has all operands current, `can_issue` is high and `flush` is low.
- R4: `stall_out` is high in a cycle exactly when, in the previous cycle, the stage held an instruction that did not issue and `flush` was low.
- R5: An instruction taken in while an earlier one is held and not issuing is kept in the skid slot. It issues after the earlier one.
- R6: The tag and operands issued come from the held copy. Changes on the input fields after the instruction is taken in have no effect on them.
- R7: An operand's value is read from the register file when the instruction is taken in. A writeback to the same address in that cycle or any later cycle before issue replaces it. A writeback in the issue cycle itself is not seen.
- R8: An operand taken in with its pending flag set is not current until a writeback to its address. The instruction issues no earlier than the cycle after that writeback.
- R9: With `flush` high, nothing issues in that cycle. The held instruction, the skidded instruction and any instruction offered in that cycle are discarded, and `stall_out` is low in the next cycle.
- R10: Under any pattern of `can_issue`, every instruction taken in and not flushed issues exactly once, in the order it was taken in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all held and offered instructions |
| in_valid | input | 1 | Decoder offers an instruction |
| in_tag | input | TAG_W | Instruction tag |
| in_reg | input | NSRC x REG_W | Source register numbers |
| in_fp | input | NSRC | Bank select per source (1 = floating-point) |
| in_pend | input | NSRC | Source has a writeback still in flight |
| stall_out | output | 1 | Decoder must hold its instruction |
| rf_addr | output | NSRC x (REG_W+1) | Register-file read addresses |
| rf_data | input | NSRC x DATA_W | Register-file read data, same cycle |
| wb_en | input | 1 | Register-file write strobe |
| wb_addr | input | REG_W+1 | Register-file write address |
| wb_data | input | DATA_W | Register-file write data |
| can_issue | input | 1 | Execution units accept an instruction |
| iss_valid | output | 1 | Instruction issued this cycle |
| iss_tag | output | TAG_W | Tag of the issued instruction |
| iss_op | output | NSRC x DATA_W | Operand values of the issued instruction |

## Verification
A bad held operand shows up at the ports as a wrong `iss_op` value in the cycle that instruction issues. The bench checks it against a register-file model sampled in that same cycle, so a missed or misrouted bypass is caught on the first issue that depends on it. A lost or doubled skid entry shows up as a tag mismatch, or as an empty scoreboard, at the next issue. A wrong stall flop shows up one cycle after the held instruction fails to issue, either as an instruction taken in that should have been refused or as a refusal that should not have happened. The stall and flush checks look for exactly that.

// File: rtl/iss_pkg.sv
// Package: default sizes shared by the issue stage and its submodules.
// Assumes: nothing beyond the parameter values below.
package iss_pkg;
    parameter int ISS_TAG_W  = 8;
    parameter int ISS_REG_W  = 5;
    parameter int ISS_DATA_W = 32;
    parameter int ISS_NSRC   = 2;
endpackage

// File: rtl/iss_rf_addr.sv
// Module: forms the register-file read addresses from the decoder's fields.
// Kept apart from the issue control so that address decode does not sit on
// the stall path. Assumes: the bank select is the address MSB.
module iss_rf_addr #(
    parameter int REG_W  = iss_pkg::ISS_REG_W,
    parameter int NSRC   = iss_pkg::ISS_NSRC,
    localparam int ADDR_W = REG_W + 1
) (
    input  logic [NSRC-1:0][REG_W-1:0]  in_reg,
    input  logic [NSRC-1:0]             in_fp,
    output logic [NSRC-1:0][ADDR_W-1:0] rf_addr
);
    // Per source: bank select on top of the register number.
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign rf_addr[i] = {in_fp[i], in_reg[i]};
    end
endmodule

// File: rtl/iss_slot.sv
// Module: one instruction holding slot with writeback snooping.
// Any write whose address matches a held operand replaces its value and marks
// it current, including a write in the same cycle the slot is loaded.
// Assumes: ld has priority over clr; the owner never raises both for a drop.
module iss_slot #(
    parameter int TAG_W  = iss_pkg::ISS_TAG_W,
    parameter int ADDR_W = iss_pkg::ISS_REG_W + 1,
    parameter int DATA_W = iss_pkg::ISS_DATA_W,
    parameter int NSRC   = iss_pkg::ISS_NSRC
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        ld,
    input  logic [TAG_W-1:0]            ld_tag,
    input  logic [NSRC-1:0][ADDR_W-1:0] ld_addr,
    input  logic [NSRC-1:0][DATA_W-1:0] ld_val,
    input  logic [NSRC-1:0]             ld_ok,
    input  logic                        wb_en,
    input  logic [ADDR_W-1:0]           wb_addr,
    input  logic [DATA_W-1:0]           wb_data,
    output logic                        q_valid,
    output logic [TAG_W-1:0]            q_tag,
    output logic [NSRC-1:0][ADDR_W-1:0] q_addr,
    output logic [NSRC-1:0][DATA_W-1:0] q_val,
    output logic [NSRC-1:0]             q_ok
);
    logic [NSRC-1:0][ADDR_W-1:0] base_addr;
    logic [NSRC-1:0][DATA_W-1:0] val_n;
    logic [NSRC-1:0]             ok_n;

    // Pick new or held operands, then apply the snooped writeback.
    always_comb begin
        base_addr = ld ? ld_addr : q_addr;
        val_n     = ld ? ld_val  : q_val;
        ok_n      = ld ? ld_ok   : q_ok;
        for (int i = 0; i < NSRC; i++) begin
            if (wb_en && (base_addr[i] == wb_addr)) begin
                val_n[i] = wb_data;
                ok_n[i]  = 1'b1;
            end
        end
    end

    // Slot state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_tag   <= '0;
            q_addr  <= '0;
            q_val   <= '0;
            q_ok    <= '0;
        end else begin
            if (ld) begin
                q_valid <= 1'b1;
                q_tag   <= ld_tag;
                q_addr  <= ld_addr;
            end else if (clr) begin
                q_valid <= 1'b0;
            end
            q_val <= val_n;
            q_ok  <= ok_n;
        end
    end
endmodule

// File: rtl/iss_stage.sv
// Module: issue stage with a flop-driven stall, a one-entry skid slot and
// writeback bypass into the held operands.
// Assumes: rf_data returns in the same cycle as rf_addr; the decoder holds
// its offer while stall_out is high; hazard detection sets in_pend.
module iss_stage #(
    parameter int TAG_W  = iss_pkg::ISS_TAG_W,
    parameter int REG_W  = iss_pkg::ISS_REG_W,
    parameter int DATA_W = iss_pkg::ISS_DATA_W,
    parameter int NSRC   = iss_pkg::ISS_NSRC,
    localparam int ADDR_W = REG_W + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        in_valid,
    input  logic [TAG_W-1:0]            in_tag,
    input  logic [NSRC-1:0][REG_W-1:0]  in_reg,
    input  logic [NSRC-1:0]             in_fp,
    input  logic [NSRC-1:0]             in_pend,
    output logic                        stall_out,
    output logic [NSRC-1:0][ADDR_W-1:0] rf_addr,
    input  logic [NSRC-1:0][DATA_W-1:0] rf_data,
    input  logic                        wb_en,
    input  logic [ADDR_W-1:0]           wb_addr,
    input  logic [DATA_W-1:0]           wb_data,
    input  logic                        can_issue,
    output logic                        iss_valid,
    output logic [TAG_W-1:0]            iss_tag,
    output logic [NSRC-1:0][DATA_W-1:0] iss_op
);
    logic                        stall_q;
    logic                        fire, accept, h_free;
    logic                        h_from_s, h_from_in, h_ld, h_clr, s_ld, s_clr;
    logic                        h_valid, s_valid;
    logic [TAG_W-1:0]            h_tag, s_tag, hl_tag;
    logic [NSRC-1:0][ADDR_W-1:0] h_addr, s_addr, hl_addr;
    logic [NSRC-1:0][DATA_W-1:0] h_val, s_val, hl_val;
    logic [NSRC-1:0]             h_ok, s_ok, hl_ok;

    // Address decode for the first-cycle register read.
    iss_rf_addr #(.REG_W(REG_W), .NSRC(NSRC)) u_addr (
        .in_reg (in_reg),
        .in_fp  (in_fp),
        .rf_addr(rf_addr)
    );

    // Slot control: issue decision, intake and routing between the slots.
    always_comb begin
        fire      = h_valid && (&h_ok) && can_issue && !flush;
        accept    = in_valid && !stall_q && !flush;
        h_free    = !h_valid || fire;
        h_from_s  = s_valid && h_free && !flush;
        h_from_in = accept && !s_valid && h_free;
        h_ld      = h_from_s || h_from_in;
        h_clr     = flush || fire;
        s_ld      = accept && !h_from_in;
        s_clr     = flush || h_from_s;
    end

    // Load source for the main slot: skid entry first, else the new offer.
    always_comb begin
        if (h_from_s) begin
            hl_tag  = s_tag;
            hl_addr = s_addr;
            hl_val  = s_val;
            hl_ok   = s_ok;
        end else begin
            hl_tag  = in_tag;
            hl_addr = rf_addr;
            hl_val  = rf_data;
            hl_ok   = ~in_pend;
        end
    end

    // Main slot: the instruction being offered for issue.
    iss_slot #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_hold (
        .clk(clk), .rst_n(rst_n), .clr(h_clr), .ld(h_ld),
        .ld_tag(hl_tag), .ld_addr(hl_addr), .ld_val(hl_val), .ld_ok(hl_ok),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .q_valid(h_valid), .q_tag(h_tag), .q_addr(h_addr), .q_val(h_val), .q_ok(h_ok)
    );

    // Skid slot: catches the instruction offered during the stall delay.
    iss_slot #(.TAG_W(TAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(NSRC)) u_skid (
        .clk(clk), .rst_n(rst_n), .clr(s_clr), .ld(s_ld),
        .ld_tag(in_tag), .ld_addr(rf_addr), .ld_val(rf_data), .ld_ok(~in_pend),
        .wb_en(wb_en), .wb_addr(wb_addr), .wb_data(wb_data),
        .q_valid(s_valid), .q_tag(s_tag), .q_addr(s_addr), .q_val(s_val), .q_ok(s_ok)
    );

    // Stall flop: set when a held instruction failed to issue this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stall_q <= 1'b0;
        else        stall_q <= h_valid && !fire && !flush;
    end

    assign stall_out = stall_q;
    assign iss_valid = fire;
    assign iss_tag   = h_tag;
    assign iss_op    = h_val;
endmodule

// File: rtl/iss_stage_chk.sv
// Checker: temporal properties of the issue stage, bound to every instance.
// Assumes: signals are sampled at the rising clock edge.
module iss_stage_chk #(
    parameter int TAG_W = iss_pkg::ISS_TAG_W,
    parameter int NSRC  = iss_pkg::ISS_NSRC
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush,
    input logic             in_valid,
    input logic             stall_out,
    input logic             can_issue,
    input logic             iss_valid,
    input logic             hold_valid,
    input logic [NSRC-1:0]  hold_ok,
    input logic [TAG_W-1:0] hold_tag,
    input logic             skid_valid
);
    // R4: a held instruction that did not issue raises stall next cycle.
    p_stall_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && !iss_valid && !flush) |=> stall_out);
    // R4: an empty stage never stalls in the following cycle.
    p_stall_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_valid |=> !stall_out);
    // R8: issue only with every operand current and downstream ready.
    p_issue_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> ((&hold_ok) && can_issue && hold_valid));
    // R9: no issue during flush, and the stage is empty after it.
    p_flush_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !iss_valid);
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!stall_out && !hold_valid && !skid_valid));
    // R5: never take an instruction in when both slots are full and stuck.
    p_no_loss_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !stall_out && !flush) |-> !(skid_valid && hold_valid && !iss_valid));
    // R6: a waiting instruction keeps its tag.
    p_tag_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_valid && !iss_valid && !flush) |=> $stable(hold_tag));
endmodule

bind iss_stage iss_stage_chk #(.TAG_W(TAG_W), .NSRC(NSRC)) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .stall_out(stall_out), .can_issue(can_issue), .iss_valid(iss_valid),
    .hold_valid(h_valid), .hold_ok(h_ok), .hold_tag(h_tag), .skid_valid(s_valid)
);

// File: tb/tb_iss_stage.sv
// Bench: scoreboard. The driver task queues each instruction taken in; the
// monitor pops on every issue and compares tag and operands with a model file.
module tb_iss_stage;
    localparam int CLK_P  = 10;
    localparam int TAG_W  = 8;
    localparam int REG_W  = 5;
    localparam int DATA_W = 32;
    localparam int NSRC   = 2;
    localparam int ADDR_W = REG_W + 1;
    localparam int NREG   = 1 << ADDR_W;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, in_valid = 1'b0;
    logic [TAG_W-1:0] in_tag = '0;
    logic [NSRC-1:0][REG_W-1:0] in_reg = '0;
    logic [NSRC-1:0] in_fp = '0, in_pend = '0;
    logic stall_out;
    logic [NSRC-1:0][ADDR_W-1:0] rf_addr;
    logic [NSRC-1:0][DATA_W-1:0] rf_data;
    logic wb_en = 1'b0;
    logic [ADDR_W-1:0] wb_addr = '0;
    logic [DATA_W-1:0] wb_data = '0;
    logic can_issue = 1'b0;
    logic iss_valid;
    logic [TAG_W-1:0] iss_tag;
    logic [NSRC-1:0][DATA_W-1:0] iss_op;

    logic [DATA_W-1:0] rf_m [NREG];
    logic [TAG_W-1:0] q_tag [$];
    logic [NSRC-1:0][ADDR_W-1:0] q_addr [$];
    int n_chk = 0, n_fail = 0;
    logic took;

    iss_stage #(.TAG_W(TAG_W), .REG_W(REG_W), .DATA_W(DATA_W), .NSRC(NSRC)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .in_tag(in_tag),
        .in_reg(in_reg), .in_fp(in_fp), .in_pend(in_pend), .stall_out(stall_out),
        .rf_addr(rf_addr), .rf_data(rf_data), .wb_en(wb_en), .wb_addr(wb_addr),
        .wb_data(wb_data), .can_issue(can_issue), .iss_valid(iss_valid),
        .iss_tag(iss_tag), .iss_op(iss_op)
    );

    always #(CLK_P/2) clk = ~clk;

    // Model register file: same-cycle read, write at the edge.
    always_comb for (int i = 0; i < NSRC; i++) rf_data[i] = rf_m[rf_addr[i]];
    always @(posedge clk) begin
        if (!rst_n) for (int k = 0; k < NREG; k++) rf_m[k] <= DATA_W'(32'h1000 + k);
        else if (wb_en) rf_m[wb_addr] <= wb_data;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; queues the instruction if it is taken in.
    task automatic cyc(input logic v, input logic [TAG_W-1:0] tg,
                       input logic [REG_W-1:0] r0, input logic [REG_W-1:0] r1,
                       input logic [NSRC-1:0] fp, input logic [NSRC-1:0] pd,
                       input logic ci, input logic fl,
                       input logic we, input logic [ADDR_W-1:0] wa, input logic [DATA_W-1:0] wd);
        @(negedge clk);
        in_valid = v; in_tag = tg; in_reg[0] = r0; in_reg[1] = r1;
        in_fp = fp; in_pend = pd; can_issue = ci; flush = fl;
        wb_en = we; wb_addr = wa; wb_data = wd;
        #1;
        took = v && !stall_out && !fl;
        if (fl) begin
            q_tag.delete();
            q_addr.delete();
        end
        if (took) begin
            q_tag.push_back(tg);
            q_addr.push_back({fp[1], r1, fp[0], r0});
        end
    endtask

    // Monitor: R10 order/no-dup, R7 operand values against the model.
    always begin
        @(negedge clk);
        #2;
        if (rst_n && iss_valid) begin
            if (q_tag.size() == 0) begin
                check("R10 issue with empty scoreboard", 64'(iss_tag), 64'hFFFF);
            end else begin
                logic [TAG_W-1:0] et;
                logic [NSRC-1:0][ADDR_W-1:0] ea;
                et = q_tag.pop_front();
                ea = q_addr.pop_front();
                check("R10 issue order", 64'(iss_tag), 64'(et));
                for (int i = 0; i < NSRC; i++)
                    check("R7 operand value", 64'(iss_op[i]), 64'(rf_m[ea[i]]));
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_P * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: act=hung exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [TAG_W-1:0] tg;
        logic [REG_W-1:0] r0, r1;
        logic [NSRC-1:0] fp, pd;
        logic pending_offer;
        // R1: quiet during reset and in the first cycle after it.
        repeat (3) @(negedge clk);
        check("R1 stall in reset", 64'(stall_out), 0);
        check("R1 issue in reset", 64'(iss_valid), 0);
        rst_n = 1'b1;
        cyc(0, 8'h00, 0, 0, 2'b00, 2'b00, 1, 0, 0, 0, 0);
        #2;
        check("R1 stall after reset", 64'(stall_out), 0);
        check("R1 issue after reset", 64'(iss_valid), 0);

        // R2: address = {bank, register number}.
        cyc(0, 8'h00, 5'd3, 5'd7, 2'b01, 2'b00, 0, 0, 0, 0, 0);
        #2;
        check("R2 addr bank fp", 64'(rf_addr[0]), 64'h23);
        check("R2 addr bank int", 64'(rf_addr[1]), 64'h07);

        // R3/R4/R5: delayed stall and skid capture.
        cyc(1, 8'hA1, 1, 2, 2'b00, 2'b00, 0, 0, 0, 0, 0);
        #2; check("R4 no stall on intake cycle", 64'(stall_out), 0);
        check("R3 no issue on intake cycle", 64'(iss_valid), 0);
        cyc(1, 8'hA2, 3, 4, 2'b00, 2'b00, 0, 0, 0, 0, 0);
        #2; check("R5 skid offer taken", 64'(took), 1);
        cyc(1, 8'hA3, 5, 6, 2'b00, 2'b00, 1, 0, 0, 0, 0);
        #2; check("R4 stall after missed issue", 64'(stall_out), 1);
        check("R3 issue first", 64'(iss_tag), 64'hA1);
        check("R4 offer refused under stall", 64'(took), 0);
        cyc(1, 8'hA3, 5, 6, 2'b00, 2'b00, 1, 0, 0, 0, 0);
        #2; check("R4 stall drops after issue", 64'(stall_out), 0);
        check("R5 skid issues second", 64'(iss_tag), 64'hA2);
        cyc(0, 8'h00, 0, 0, 2'b00, 2'b00, 1, 0, 0, 0, 0);
        #2; check("R10 third in order", 64'(iss_tag), 64'hA3);

        // R6: input changes after intake do not reach the issued copy.
        cyc(1, 8'hB1, 5, 6, 2'b00, 2'b00, 0, 0, 0, 0, 0);
        cyc(0, 8'hFF, 9, 10, 2'b11, 2'b11, 0, 0, 0, 0, 0);
        cyc(0, 8'hEE, 11, 12, 2'b11, 2'b11, 1, 0, 0, 0, 0);
        #2; check("R6 held tag", 64'(iss_tag), 64'hB1);
        check("R6 held operand", 64'(iss_op[0]), 64'h1005);

        // R7: same-cycle bypass, later bypass, issue-cycle write ignored.
        cyc(1, 8'hC1, 2, 3, 2'b00, 2'b00, 0, 0, 1, 6'd2, 32'hDEAD0001);
        cyc(0, 8'h00, 0, 0, 2'b00, 2'b00, 1, 0, 0, 0, 0);
        #2; check("R7 intake-cycle write seen", 64'(iss_op[0]), 64'hDEAD0001);
        cyc(1, 8'hC2, 4, 3, 2'b00, 2'b00, 0, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 2'b00, 2'b00, 0, 0, 1, 6'd4, 32'hBEEF0004);
        cyc(0, 8'h00, 0, 0, 2'b00, 2'b00, 1, 0, 1, 6'd4, 32'h55555555);
        #2; check("R7 later write seen", 64'(iss_op[0]), 64'hBEEF0004);

        // R8: pending operand waits for its writeback.
        cyc(1, 8'hD1, 6, 3, 2'b00, 2'b01, 1, 0, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 2'b00, 2'b00, 1, 0, 0, 0, 0);
        #2; check("R8 pending blocks issue", 64'(iss_valid), 0);
        cyc(0, 8'h00, 0, 0, 2'b00, 2'b00, 1, 0, 1, 6'd6, 32'h0000600D);
        #2; check("R8 write cycle still blocked", 64'(iss_valid), 0);
        cyc(0, 8'h00, 0, 0, 2'b00, 2'b00, 1, 0, 0, 0, 0);
        #2; check("R8 issues after write", 64'(iss_valid), 1);
        check("R8 written value", 64'(iss_op[0]), 64'h600D);

        // R9: flush with both slots full, then flush of an incoming offer.
        cyc(1, 8'hE1, 1, 1, 2'b00, 2'b00, 0, 0, 0, 0, 0);
        cyc(1, 8'hE2, 1, 1, 2'b00, 2'b00, 0, 0, 0, 0, 0);
        cyc(1, 8'hE3, 1, 1, 2'b00, 2'b00, 1, 1, 0, 0, 0);
        #2; check("R9 no issue in flush", 64'(iss_valid), 0);
        cyc(0, 8'h00, 0, 0, 2'b00, 2'b00, 1, 0, 0, 0, 0);
        #2; check("R9 stall low after flush", 64'(stall_out), 0);
        check("R9 nothing left to issue", 64'(iss_valid), 0);
        cyc(1, 8'hE4, 1, 1, 2'b00, 2'b00, 1, 1, 0, 0, 0);
        cyc(0, 8'h00, 0, 0, 2'b00, 2'b00, 1, 0, 0, 0, 0);
        #2; check("R9 flushed offer dropped", 64'(iss_valid), 0);

        // R10: random can_issue, offers, writebacks and rare flushes.
        pending_offer = 1'b0;
        tg = 8'h10; r0 = '0; r1 = '0; fp = '0; pd = '0;
        for (int n = 0; n < 4000; n++) begin
            logic v, ci, fl, we;
            if (!pending_offer && ($urandom_range(0, 9) < 7)) begin
                pending_offer = 1'b1;
                tg = tg + 8'd1;
                r0 = REG_W'($urandom_range(0, 3));
                r1 = REG_W'($urandom_range(0, 3));
                fp = NSRC'($urandom_range(0, 3));
                pd = {($urandom_range(0, 9) < 2), ($urandom_range(0, 9) < 2)};
            end
            v  = pending_offer;
            ci = ($urandom_range(0, 1) == 1);
            fl = ($urandom_range(0, 99) == 0);
            we = ($urandom_range(0, 9) < 4);
            cyc(v, tg, r0, r1, fp, pd, ci, fl, we,
                {1'($urandom_range(0, 1)), REG_W'($urandom_range(0, 3))}, DATA_W'($urandom));
            if (took || fl) pending_offer = 1'b0;
        end
        // Drain: write every used address so pending operands resolve.
        for (int k = 0; k < 48; k++)
            cyc(0, 8'h00, 0, 0, 2'b00, 2'b00, 1, 0, 1,
                {1'(k[2]), REG_W'(k[1:0])}, DATA_W'($urandom));
        #2; check("R10 scoreboard empty", 64'(q_tag.size()), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule